// File: doc/BRIEF.md
# Segment Row Streamer with Common-Line Frame Marker

The block reads a row-major frame buffer one pixel at a time and streams each row to a chain of cascaded segment drivers over a single serial data line. A slow shift clock is made by dividing the system clock. Each row goes out in column order. When the row width is not a multiple of four, zero-valued filler bits are added at the end. After the last bit and a gap with the shift clock idle, a latch strobe is pulsed. The drivers take that strobe as the moment to show the new row.

The same strobe clocks the common-line shift chain. The block raises a frame marker during the first row of every frame so that the chain picks it up on the first strobe. It also flips the drive-polarity signal once per frame, at the strobe that begins the first row. One start pulse runs one complete frame of `ROWS` row transfers. Start pulses that arrive while a frame is running have no effect.

The pixel source is combinational. The block places a row and column index on its read port, and the bit for that index must be present on the data input in the same cycle.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: While reset is asserted, and immediately after it, `shiftClk`, `serData`, `latchPulse`, `polarity` and `frameMark` are all 0. An asynchronous reset in the middle of a frame stops the transfer.
- R2: Each row is sent as serial bits in column order, starting at column 0. The bit present on `serData` at the falling edge of `shiftClk` equals the buffer pixel at (row, column) for every column below `COLS`.
- R3: Each row uses exactly `PAD = 4*ceil(COLS/4)` falling edges of `shiftClk`. The filler bits at columns `COLS..PAD-1` are driven as 0, whatever `pixBit` holds at those columns.
- R4: `serData` changes only together with a rising edge of `shiftClk`, and it holds steady for as long as `shiftClk` is high.
- R5: One start pulse gives exactly `ROWS` latch pulses, one per row, for rows 0 to `ROWS-1` in order. The block then stays idle.
- R6: `shiftClk` and `latchPulse` are never high at the same time. There are at least `2*CP_HALF` system cycles with both low between the last fall of `shiftClk` and the rise of `latchPulse`, and again between the fall of `latchPulse` and the next rise of `shiftClk`.
- R7: `latchPulse` stays high for exactly `2*CP_HALF` system cycles, which is one shift-clock period.
- R8: `frameMark` is high across the latch pulse of row 0 and low across every other latch pulse. It never changes while `latchPulse` is high or at the moment it falls. A common-line shifter that loads the marker on the falling edge of `latchPulse` therefore points at line r after the latch of row r.
- R9: `polarity` flips once per frame, in the same cycle that `latchPulse` rises for row 0. It does not change at any other time.
- R10: A start pulse received while a frame is in progress is ignored. The frame runs to its end with the same number of latch pulses and a single polarity flip.
- R11: Each high phase of `shiftClk` lasts exactly `CP_HALF` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Starts one frame when the block is idle |
| pixRow | output | ROW_W | Row index of the pixel being read |
| pixCol | output | COL_W | Column index of the pixel being read (may exceed COLS-1 during filler bits) |
| pixBit | input | 1 | Pixel value at (pixRow, pixCol), valid in the same cycle |
| shiftClk | output | 1 | Serial shift clock to the segment drivers; data is taken on its falling edge |
| serData | output | 1 | Serial pixel data |
| latchPulse | output | 1 | Row latch strobe, also clocks the common-line chain |
| polarity | output | 1 | Drive-polarity alternation signal |
| frameMark | output | 1 | Frame marker bit entered into the common-line chain |

## Verification
The bench runs with a row width of 10, which pads to 12. It feeds `pixBit = 1` for the out-of-range columns, so a design that forwards the read port during filler bits, or that stops at 10 bits, is caught by the bit count and filler checks. A bench model of the drivers and the common chain rebuilds each row and the line pointer. A design that loads data at the wrong point in the shift clock shows up as a column skew. A design that drops the marker at the same edge as the latch shows up as a wrong line number. Start pulses repeated in the middle of a frame would restart a careless design. That would add latch pulses and extra polarity flips. A reset in the middle of a frame must leave every output low.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // Strobes from the sequencer to the datapath, at most a few per cycle.
  typedef struct packed {
    logic frameBegin;  // first bit of a new frame
    logic frameEnd;    // tail gap of the frame finished
    logic cpRise;      // raise shift clock and present the next bit
    logic cpFall;      // lower shift clock
    logic colStep;     // advance the column pointer
    logic colClr;      // return the column pointer to 0
    logic loadRise;    // raise the latch strobe
    logic loadFall;    // lower the latch strobe and step the row
  } scan_strobe_t;

  // Position flags that the datapath returns to the sequencer.
  typedef struct packed {
    logic lastCol;
    logic lastRow;
  } scan_status_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HIGH,
    S_LOW,
    S_PRE,
    S_LATCH,
    S_POST,
    S_TAIL
  } scan_state_t;

endpackage

// File: rtl/scan_ctrl_fsm.sv
module scan_ctrl_fsm
  import lcd_scan_pkg::*;
#(
  parameter int CP_HALF = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  scan_status_t stat,
  output scan_strobe_t ctl
);

  localparam int TMR_W = (2 * CP_HALF > 2) ? $clog2(2 * CP_HALF) : 1;
  localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(CP_HALF - 1);
  localparam logic [TMR_W-1:0] FULL_LD = TMR_W'(2 * CP_HALF - 1);

  scan_state_t state, stateNext;
  logic [TMR_W-1:0] tmr, tmrNext;
  logic tmrDone;

  assign tmrDone = (tmr == '0);

  always_comb begin
    stateNext = state;
    tmrNext   = tmrDone ? tmr : tmr - 1'b1;
    ctl       = '0;
    unique case (state)
      S_IDLE: begin
        if (startPulse) begin
          ctl.frameBegin = 1'b1;
          ctl.cpRise     = 1'b1;
          tmrNext        = HALF_LD;
          stateNext      = S_HIGH;
        end
      end
      S_HIGH: begin
        if (tmrDone) begin
          ctl.cpFall = 1'b1;
          if (stat.lastCol) begin
            ctl.colClr = 1'b1;
            tmrNext    = FULL_LD;
            stateNext  = S_PRE;
          end else begin
            ctl.colStep = 1'b1;
            tmrNext     = HALF_LD;
            stateNext   = S_LOW;
          end
        end
      end
      S_LOW: begin
        if (tmrDone) begin
          ctl.cpRise = 1'b1;
          tmrNext    = HALF_LD;
          stateNext  = S_HIGH;
        end
      end
      S_PRE: begin
        if (tmrDone) begin
          ctl.loadRise = 1'b1;
          tmrNext      = FULL_LD;
          stateNext    = S_LATCH;
        end
      end
      S_LATCH: begin
        if (tmrDone) begin
          ctl.loadFall = 1'b1;
          tmrNext      = FULL_LD;
          stateNext    = stat.lastRow ? S_TAIL : S_POST;
        end
      end
      S_POST: begin
        if (tmrDone) begin
          ctl.cpRise = 1'b1;
          tmrNext    = HALF_LD;
          stateNext  = S_HIGH;
        end
      end
      S_TAIL: begin
        if (tmrDone) begin
          ctl.frameEnd = 1'b1;
          stateNext    = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      tmr   <= '0;
    end else begin
      state <= stateNext;
      tmr   <= tmrNext;
    end
  end

endmodule

// File: rtl/scan_ctrl_dp.sv
module scan_ctrl_dp
  import lcd_scan_pkg::*;
#(
  parameter int COLS  = 240,
  parameter int ROWS  = 100,
  parameter int PAD   = 240,
  parameter int COL_W = 8,
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  scan_strobe_t     ctl,
  input  logic             pixBit,
  output scan_status_t     stat,
  output logic [ROW_W-1:0] pixRow,
  output logic [COL_W-1:0] pixCol,
  output logic             cp,
  output logic             sdi,
  output logic             load,
  output logic             altM,
  output logic             frm
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAD - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic padBit;
  logic firstRow;

  assign pixCol       = col;
  assign pixRow       = row;
  assign firstRow     = (row == '0);
  assign stat.lastCol = (col == COL_LAST);
  assign stat.lastRow = (row == ROW_LAST);

  // Filler columns exist only when the width is not a multiple of 4.
  generate
    if (PAD == COLS) begin : g_noPad
      assign padBit = pixBit;
    end else begin : g_pad
      localparam logic [COL_W-1:0] COL_END = COL_W'(COLS);
      assign padBit = (col < COL_END) ? pixBit : 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      col <= '0;
    end else if (ctl.colClr) begin
      col <= '0;
    end else if (ctl.colStep) begin
      col <= col + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      row <= '0;
    end else if (ctl.loadFall) begin
      row <= stat.lastRow ? '0 : row + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cp  <= 1'b0;
      sdi <= 1'b0;
    end else if (ctl.cpRise) begin
      cp  <= 1'b1;
      sdi <= padBit;
    end else if (ctl.cpFall) begin
      cp  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      load <= 1'b0;
      altM <= 1'b0;
    end else if (ctl.loadRise) begin
      load <= 1'b1;
      if (firstRow) altM <= ~altM;
    end else if (ctl.loadFall) begin
      load <= 1'b0;
    end
  end

  // The marker is dropped at the first bit of row 1 or after the tail gap,
  // never at a latch edge, so the common chain always sees it settled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frm <= 1'b0;
    end else if (ctl.frameBegin) begin
      frm <= 1'b1;
    end else if (ctl.frameEnd || (ctl.cpRise && !firstRow)) begin
      frm <= 1'b0;
    end
  end

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int COLS    = 240,
  parameter int ROWS    = 100,
  parameter int CP_HALF = 2,
  localparam int PAD    = ((COLS + 3) / 4) * 4,
  localparam int COL_W  = (PAD > 1) ? $clog2(PAD) : 1,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  output logic [ROW_W-1:0] pixRow,
  output logic [COL_W-1:0] pixCol,
  input  logic             pixBit,
  output logic             shiftClk,
  output logic             serData,
  output logic             latchPulse,
  output logic             polarity,
  output logic             frameMark
);

  scan_strobe_t ctl;
  scan_status_t stat;

  scan_ctrl_fsm #(
    .CP_HALF(CP_HALF)
  ) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .stat      (stat),
    .ctl       (ctl)
  );

  scan_ctrl_dp #(
    .COLS (COLS),
    .ROWS (ROWS),
    .PAD  (PAD),
    .COL_W(COL_W),
    .ROW_W(ROW_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .pixBit(pixBit),
    .stat  (stat),
    .pixRow(pixRow),
    .pixCol(pixCol),
    .cp    (shiftClk),
    .sdi   (serData),
    .load  (latchPulse),
    .altM  (polarity),
    .frm   (frameMark)
  );

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int CP_HALF = 2
) (
  input logic clk,
  input logic rstN,
  input logic shiftClk,
  input logic serData,
  input logic latchPulse,
  input logic polarity,
  input logic frameMark
);

  localparam logic [15:0] GAP = 16'(2 * CP_HALF);

  logic [15:0] cpLowCnt, loadLowCnt, loadHighCnt, cpHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpLowCnt    <= '0;
      loadLowCnt  <= '1;
      loadHighCnt <= '0;
      cpHighCnt   <= '0;
    end else begin
      cpLowCnt    <= shiftClk   ? '0 : ((cpLowCnt   == '1) ? cpLowCnt   : cpLowCnt + 1'b1);
      loadLowCnt  <= latchPulse ? '0 : ((loadLowCnt == '1) ? loadLowCnt : loadLowCnt + 1'b1);
      loadHighCnt <= !latchPulse ? '0 : ((loadHighCnt == '1) ? loadHighCnt : loadHighCnt + 1'b1);
      cpHighCnt   <= !shiftClk  ? '0 : ((cpHighCnt  == '1) ? cpHighCnt  : cpHighCnt + 1'b1);
    end
  end

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftClk && latchPulse));

  // R6
  gap_before_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchPulse && !$past(latchPulse)) |-> (cpLowCnt >= GAP));

  // R6
  gap_after_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk && !$past(shiftClk)) |-> (loadLowCnt >= GAP));

  // R7
  latch_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(latchPulse) |-> (loadHighCnt == GAP));

  // R11
  clk_high_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftClk) |-> (cpHighCnt == 16'(CP_HALF)));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk && $past(shiftClk)) |-> (serData == $past(serData)));

  // R9
  polarity_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (polarity != $past(polarity)) |-> (latchPulse && !$past(latchPulse)));

  // R8
  marker_settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchPulse || $past(latchPulse)) |-> (frameMark == $past(frameMark)));

endmodule

bind lcd_scan_ctrl lcd_scan_chk #(.CP_HALF(CP_HALF)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .shiftClk  (shiftClk),
  .serData   (serData),
  .latchPulse(latchPulse),
  .polarity  (polarity),
  .frameMark (frameMark)
);

// File: tb/sim_lcd_scan_ctrl.sv
`timescale 1ns/1ps
module sim_lcd_scan_ctrl;

  localparam int COLS    = 10;
  localparam int ROWS    = 3;
  localparam int CP_HALF = 2;
  localparam int PAD     = ((COLS + 3) / 4) * 4;
  localparam int COL_W   = (PAD > 1) ? $clog2(PAD) : 1;
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int GAP     = 2 * CP_HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [ROW_W-1:0] pixRow;
  logic [COL_W-1:0] pixCol;
  logic pixBit;
  logic shiftClk, serData, latchPulse, polarity, frameMark;

  int checks = 0;
  int fails  = 0;
  logic fb [0:ROWS-1][0:COLS-1];

  always #4 clk = ~clk;

  // Filler columns read as 1 so that forwarding them would be visible.
  always_comb begin
    if (int'(pixCol) < COLS && int'(pixRow) < ROWS) pixBit = fb[pixRow][pixCol];
    else pixBit = 1'b1;
  end

  lcd_scan_ctrl #(.COLS(COLS), .ROWS(ROWS), .CP_HALF(CP_HALF)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .pixRow(pixRow), .pixCol(pixCol), .pixBit(pixBit),
    .shiftClk(shiftClk), .serData(serData), .latchPulse(latchPulse),
    .polarity(polarity), .frameMark(frameMark)
  );

  // ---------------- driver and common-chain model ----------------
  logic [15:0] rxBits;
  int rxCnt;
  logic prevCp, prevLd, prevM, sdiHold, frmAtRise, flipAtRise;
  int cpRun, ldRun, cpLowRun, ldLowRun, line;
  int vSdi, vCpW, vGap, vOvl, vLdW, vM;
  int logCnt;
  logic [15:0] logBits [0:63];
  int logN [0:63];
  logic logFrmR [0:63];
  logic logFrmF [0:63];
  logic logFlip [0:63];
  int logLine [0:63];

  always @(negedge clk) begin
    if (!rstN) begin
      rxBits = '0; rxCnt = 0; prevCp = 0; prevLd = 0; prevM = 0;
      cpRun = 0; ldRun = 0; cpLowRun = 1000; ldLowRun = 1000; line = 0;
    end else begin
      if (shiftClk && latchPulse) vOvl++;
      if (shiftClk && !prevCp) begin
        if (ldLowRun < GAP) vGap++;
        sdiHold = serData; cpRun = 1;
      end else if (shiftClk && prevCp) begin
        if (serData != sdiHold) vSdi++;
        cpRun++;
      end else if (!shiftClk && prevCp) begin
        if (cpRun != CP_HALF) vCpW++;
        if (rxCnt < 16) rxBits[rxCnt] = sdiHold;
        rxCnt++;
      end
      if (latchPulse && !prevLd) begin
        if (cpLowRun < GAP) vGap++;
        frmAtRise = frameMark; flipAtRise = (polarity != prevM); ldRun = 1;
      end else if (latchPulse && prevLd) begin
        ldRun++;
      end else if (!latchPulse && prevLd) begin
        if (ldRun != GAP) vLdW++;
        line = frameMark ? 0 : line + 1;
        if (logCnt < 64) begin
          logBits[logCnt] = rxBits; logN[logCnt] = rxCnt;
          logFrmR[logCnt] = frmAtRise; logFrmF[logCnt] = frameMark;
          logFlip[logCnt] = flipAtRise; logLine[logCnt] = line;
        end
        logCnt++;
        rxBits = '0; rxCnt = 0;
      end
      if ((polarity != prevM) && !(latchPulse && !prevLd)) vM++;
      cpLowRun = shiftClk ? 0 : cpLowRun + 1;
      ldLowRun = latchPulse ? 0 : ldLowRun + 1;
      prevCp = shiftClk; prevLd = latchPulse; prevM = polarity;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic waitLoads(input int target);
    while (logCnt < target) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  // Rows of one frame against the buffer, marker, line and polarity.
  task automatic checkFrame(input int base);
    for (int r = 0; r < ROWS; r++) begin
      int e = base + r;
      logic [15:0] expv = '0;
      for (int c = 0; c < COLS; c++) expv[c] = fb[r][c];
      check("R2 row bits", int'(logBits[e][COLS-1:0]), int'(expv[COLS-1:0]));
      check("R3 filler bits zero", int'(logBits[e] >> COLS), 0);
      check("R3 bit count", logN[e], PAD);
      check("R8 marker at latch", int'(logFrmR[e]), (r == 0) ? 1 : 0);
      check("R8 marker steady", int'(logFrmF[e]), int'(logFrmR[e]));
      check("R8 common line", logLine[e], r);
      check("R9 polarity flip", int'(logFlip[e]), (r == 0) ? 1 : 0);
    end
  endtask

  task automatic checkTiming();
    check("R4 data steady while clock high", vSdi, 0);
    check("R11 clock high width", vCpW, 0);
    check("R6 gap", vGap, 0);
    check("R6 overlap", vOvl, 0);
    check("R7 latch width", vLdW, 0);
    check("R9 stray polarity change", vM, 0);
  endtask

  task automatic runPattern(input int kind, inout logic mExp);
    int base;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        case (kind)
          0: fb[r][c] = 1'b1;
          1: fb[r][c] = logic'((r + c) % 2);
          default: fb[r][c] = logic'(((r * 7 + c * 3) % 5) == 0);
        endcase
    base = logCnt;
    pulseStart();
    waitLoads(base + ROWS);
    check("R5 latch count", logCnt - base, ROWS);
    mExp = ~mExp;
    check("R9 polarity after frame", int'(polarity), int'(mExp));
    checkFrame(base);
    checkTiming();
  endtask

  task automatic testResetState();
    check("R1 shiftClk in reset", int'(shiftClk), 0);
    check("R1 latch in reset", int'(latchPulse), 0);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle outputs", int'({shiftClk, serData, latchPulse, polarity, frameMark}), 0);
  endtask

  task automatic testStartIgnored(inout logic mExp);
    int base = logCnt;
    pulseStart();
    repeat (25) @(negedge clk);
    pulseStart();
    while (logCnt < base + 1) @(negedge clk);
    repeat (5) @(negedge clk);
    pulseStart();
    waitLoads(base + ROWS);
    repeat (100) @(negedge clk);
    check("R10 latch count with extra starts", logCnt - base, ROWS);
    check("R10 idle after frame", int'(shiftClk | latchPulse), 0);
    mExp = ~mExp;
    check("R10 single polarity flip", int'(polarity), int'(mExp));
    checkFrame(base);
  endtask

  task automatic testMidReset();
    pulseStart();
    repeat (40) @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 outputs low in mid-frame reset",
          int'({shiftClk, serData, latchPulse, polarity, frameMark}), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (80) @(negedge clk);
    check("R1 stays idle after reset", int'(shiftClk | latchPulse), 0);
  endtask

  initial begin
    logic mExp = 1'b0;
    logCnt = 0; vSdi = 0; vCpW = 0; vGap = 0; vOvl = 0; vLdW = 0; vM = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) fb[r][c] = 1'b0;
    repeat (3) @(negedge clk);
    testResetState();
    runPattern(0, mExp);
    runPattern(1, mExp);
    runPattern(2, mExp);
    testStartIgnored(mExp);
    testMidReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wdog, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule